// File: doc/BRIEF.md
# Bus Idle Gap Break Generator

This block sits beside a shared open-drain serial data line on a master/slave bus. A slave on that bus may only get the master's attention in a quiet window. The window is a long stretch with the line held low, followed by a shorter stretch with the line idle high. When software or a neighbouring block has asked for attention, the generator then pulls the line low for a fixed time. This pulse is the "slave break". After the pulse it releases the line again.

All timing is counted in periods of an external tick enable of 0.5 ms, so there are 2000 ticks per second. The line level is sampled only on tick cycles. A pulse on `pkt_done` means the byte/packet receiver has just finished a transfer. That activity cancels any window detection in progress. The drive output is active low: while `line_drv_n` is 0 the pad must pull the line to ground, and while it is 1 the pad is high impedance.

Top module: `gapbrk_top`

## Requirements
- R1: A synchronous active-high reset, including one applied during a break, releases the line (`line_drv_n`=1), clears `brk_busy`, `brk_done` and any pending request, and returns the block to the low-window search.
- R2: The low window needs LOW_TICKS (default 10, i.e. 5 ms) consecutive tick samples with `line_in`=0. A high sample during this window restarts the count from zero.
- R3: After the low window, HIGH_TICKS (default 4, i.e. 2 ms) consecutive high samples qualify the gap. If a request is pending on the qualifying tick cycle (a strobe in that same cycle counts), `line_drv_n` goes to 0 and `brk_busy` goes to 1 on the clock edge of that tick.
- R4: In the high window, a low sample that follows at least one high sample restarts only the high window. A fresh run of HIGH_TICKS high samples then qualifies without a new low window.
- R5: A low sample on the very first sample of the high window throws the whole sequence back to the low-window search.
- R6: If no request is pending when the high window qualifies, no break is issued. The high count saturates and does not wrap, so further high samples never start a break until the high window is re-entered or restarted.
- R7: A break holds `line_drv_n`=0 and `brk_busy`=1 for exactly BREAK_TICKS ticks (default 10, i.e. 5 ms). On the edge of the last tick the line is released, and `brk_done` pulses high for one clock.
- R8: The pending request is cleared when a break ends. A strobe in that final cycle is also dropped. A later qualified gap with no new strobe issues no break.
- R9: A `pkt_done` pulse outside a break restarts detection at the low-window search. During a break it has no effect, and the break runs to full length.
- R10: `line_in` is ignored on clock cycles without `tick`. Line changes between ticks neither restart nor advance any window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-clock enable every 0.5 ms |
| line_in | input | 1 | Synchronised level of the shared data line |
| brk_req | input | 1 | One-clock strobe asking for a break |
| pkt_done | input | 1 | One-clock pulse at the end of a received transfer |
| line_drv_n | output | 1 | Drive enable, 0 = pull the line low, 1 = release |
| brk_busy | output | 1 | High while the break pulse is on the line |
| brk_done | output | 1 | One-clock pulse when a break finishes |

## Verification
The bench covers the two different restart rules of the high window. A design that merged them would either issue a break after a single stray low sample, or miss the gap after a brief glitch. It also checks that a request arriving after qualification is ignored. A wrapping counter would instead fire a spurious break about 16 ticks later. Further runs check that the request is consumed at the end of a break, since a sticky request would produce a second break in the next gap. They also check that a packet pulse aborts detection but not a break already in progress, and that line glitches between ticks are ignored. Every clock is compared against a behavioural model, so a break that is one tick short or long, or starts a cycle late, shows up as a mismatch on `line_drv_n` or `brk_done`.

// File: rtl/gapbrk_pkg.sv
package gapbrk_pkg;

  typedef enum logic [1:0] {
    GB_LOW   = 2'd0,
    GB_HIGH  = 2'd1,
    GB_BREAK = 2'd2
  } gb_phase_e;

  // widest tick target of the three windows
  function automatic int unsigned gb_max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // counter width able to hold every target value
  function automatic int unsigned gb_cnt_width(int unsigned a, int unsigned b, int unsigned c);
    return $clog2(gb_max3(a, b, c) + 1);
  endfunction

endpackage

// File: rtl/gapbrk_tick_cnt.sv
module gapbrk_tick_cnt #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] CNT_TOP = {CW{1'b1}};

  function automatic logic [CW-1:0] sat_inc(logic [CW-1:0] v);
    return (v == CNT_TOP) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= sat_inc(cnt);
  end

  // saturation instead of wrap keeps a passed target from recurring
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && cnt == CNT_TOP) |=> (cnt == CNT_TOP));

endmodule

// File: rtl/gapbrk_req_latch.sv
module gapbrk_req_latch (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic consume,
  output logic pend_q,
  output logic pend_eff
);

  // a strobe is visible in the cycle it arrives
  assign pend_eff = pend_q | strobe;

  always_ff @(posedge clk) begin
    if (rst || consume) pend_q <= 1'b0;
    else if (strobe)    pend_q <= 1'b1;
  end

  p_consume_clears_r8: assert property (@(posedge clk) disable iff (rst)
    consume |=> !pend_q);

endmodule

// File: rtl/gapbrk_seq.sv
module gapbrk_seq
  import gapbrk_pkg::*;
#(
  parameter int unsigned LOW_TICKS   = 10,
  parameter int unsigned HIGH_TICKS  = 4,
  parameter int unsigned BREAK_TICKS = 10,
  parameter int unsigned CW          = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          line,
  input  logic          pkt_done,
  input  logic          pend_eff,
  input  logic [CW-1:0] cnt,
  output logic          cnt_clr,
  output logic          cnt_inc,
  output logic          consume,
  output logic          drv_n,
  output logic          busy,
  output logic          done
);

  localparam logic [CW-1:0] LOW_LAST   = CW'(LOW_TICKS - 1);
  localparam logic [CW-1:0] HIGH_LAST  = CW'(HIGH_TICKS - 1);
  localparam logic [CW-1:0] BREAK_LAST = CW'(BREAK_TICKS - 1);

  gb_phase_e phase, phase_nxt;
  logic      hi_seen, hi_seen_nxt;
  logic      done_nxt;

  // named events for the checks
  logic low_ok, high_qual, brk_start, brk_end, hi_restart, full_restart;

  always_comb begin
    phase_nxt    = phase;
    hi_seen_nxt  = hi_seen;
    cnt_clr      = 1'b0;
    cnt_inc      = 1'b0;
    consume      = 1'b0;
    done_nxt     = 1'b0;
    low_ok       = 1'b0;
    high_qual    = 1'b0;
    brk_start    = 1'b0;
    brk_end      = 1'b0;
    hi_restart   = 1'b0;
    full_restart = 1'b0;
    case (phase)
      GB_BREAK: begin
        if (tick) begin
          if (cnt == BREAK_LAST) begin
            brk_end   = 1'b1;
            phase_nxt = GB_LOW;
            cnt_clr   = 1'b1;
            consume   = 1'b1;
            done_nxt  = 1'b1;
          end else begin
            cnt_inc = 1'b1;
          end
        end
      end
      default: begin
        if (pkt_done) begin
          phase_nxt   = GB_LOW;
          cnt_clr     = 1'b1;
          hi_seen_nxt = 1'b0;
        end else if (tick) begin
          if (phase == GB_LOW) begin
            if (line) begin
              cnt_clr = 1'b1;
            end else if (cnt == LOW_LAST) begin
              low_ok      = 1'b1;
              phase_nxt   = GB_HIGH;
              cnt_clr     = 1'b1;
              hi_seen_nxt = 1'b0;
            end else begin
              cnt_inc = 1'b1;
            end
          end else begin
            if (!line) begin
              cnt_clr     = 1'b1;
              hi_seen_nxt = 1'b0;
              if (hi_seen) hi_restart = 1'b1;
              else begin
                full_restart = 1'b1;
                phase_nxt    = GB_LOW;
              end
            end else begin
              hi_seen_nxt = 1'b1;
              high_qual   = (cnt == HIGH_LAST);
              if (high_qual && pend_eff) begin
                brk_start = 1'b1;
                phase_nxt = GB_BREAK;
                cnt_clr   = 1'b1;
              end else begin
                cnt_inc = 1'b1;
              end
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= GB_LOW;
      hi_seen <= 1'b0;
      drv_n   <= 1'b1;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      phase   <= phase_nxt;
      hi_seen <= hi_seen_nxt;
      drv_n   <= (phase_nxt != GB_BREAK);
      busy    <= (phase_nxt == GB_BREAK);
      done    <= done_nxt;
    end
  end

  // R3: the line is only pulled on a tick with a pending request
  p_start_needs_req_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(drv_n) |-> $past(tick && pend_eff && line));

  // R7: release coincides with the completion pulse
  p_release_done_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_n) |-> done);

  // R7: the break counter never passes its target while driving
  p_break_len_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt < CW'(BREAK_TICKS)));

  // R9: packet activity outside a break returns to the low search
  p_pkt_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (pkt_done && phase != GB_BREAK) |=> (phase == GB_LOW && drv_n));

  // R10: without a tick or packet pulse the phase stays put
  p_tick_only_r10: assert property (@(posedge clk) disable iff (rst)
    (!tick && !pkt_done) |=> $stable(phase));

  // R5: a low first sample of the high window leaves the line released
  p_full_restart_r5: assert property (@(posedge clk) disable iff (rst)
    full_restart |=> (phase == GB_LOW && drv_n));

endmodule

// File: rtl/gapbrk_top.sv
module gapbrk_top #(
  parameter int unsigned LOW_TICKS   = 10,
  parameter int unsigned HIGH_TICKS  = 4,
  parameter int unsigned BREAK_TICKS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic line_in,
  input  logic brk_req,
  input  logic pkt_done,
  output logic line_drv_n,
  output logic brk_busy,
  output logic brk_done
);

  localparam int unsigned CW =
    gapbrk_pkg::gb_cnt_width(LOW_TICKS, HIGH_TICKS, BREAK_TICKS);

  logic [CW-1:0] cnt;
  logic          cnt_clr, cnt_inc;
  logic          pend_q, pend_eff, consume;

  gapbrk_tick_cnt #(.CW(CW)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (cnt_clr),
    .inc (cnt_inc),
    .cnt (cnt)
  );

  gapbrk_req_latch u_req (
    .clk      (clk),
    .rst      (rst),
    .strobe   (brk_req),
    .consume  (consume),
    .pend_q   (pend_q),
    .pend_eff (pend_eff)
  );

  gapbrk_seq #(
    .LOW_TICKS   (LOW_TICKS),
    .HIGH_TICKS  (HIGH_TICKS),
    .BREAK_TICKS (BREAK_TICKS),
    .CW          (CW)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .line     (line_in),
    .pkt_done (pkt_done),
    .pend_eff (pend_eff),
    .cnt      (cnt),
    .cnt_clr  (cnt_clr),
    .cnt_inc  (cnt_inc),
    .consume  (consume),
    .drv_n    (line_drv_n),
    .busy     (brk_busy),
    .done     (brk_done)
  );

  // R8: once a break completes no request survives
  p_done_clears_req_r8: assert property (@(posedge clk) disable iff (rst)
    brk_done |-> !pend_q);

  // R1: first cycle after reset the line is released
  p_reset_release_r1: assert property (@(posedge clk)
    $past(rst) |-> (line_drv_n && !brk_busy && !brk_done));

endmodule

// File: tb/gapbrk_top_bench.sv
module gapbrk_top_bench;

  localparam int LT = 10;
  localparam int HT = 4;
  localparam int BT = 10;
  localparam int TP = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, tick = 1'b0, line_in = 1'b0, brk_req = 1'b0, pkt_done = 1'b0;
  wire  line_drv_n, brk_busy, brk_done;

  int total = 0, bad = 0, done_seen = 0, cyc = 0;

  gapbrk_top u_gapbrk_top (
    .clk(clk), .rst(rst), .tick(tick), .line_in(line_in), .brk_req(brk_req),
    .pkt_done(pkt_done), .line_drv_n(line_drv_n), .brk_busy(brk_busy), .brk_done(brk_done)
  );

  // behavioural reference: phase 0 low search, 1 high search, 2 break
  int ph = 0, n = 0;
  bit seen = 0, pend = 0, m_done = 0;

  always @(posedge clk) begin
    bit pe;
    cyc++;
    pe = pend || brk_req;
    m_done = 0;
    if (rst) begin
      ph = 0; n = 0; seen = 0; pend = 0;
    end else if (ph == 2) begin
      pend = pe;
      if (tick) begin
        n++;
        if (n == BT) begin ph = 0; n = 0; pend = 0; m_done = 1; end
      end
    end else if (pkt_done) begin
      ph = 0; n = 0; seen = 0; pend = pe;
    end else begin
      pend = pe;
      if (tick && ph == 0) begin
        if (line_in) n = 0;
        else begin
          n++;
          if (n == LT) begin ph = 1; n = 0; seen = 0; end
        end
      end else if (tick && ph == 1) begin
        if (!line_in) begin
          n = 0;
          if (!seen) ph = 0;
          seen = 0;
        end else begin
          seen = 1;
          if (n < 15) n++;
          if (n == HT && pe) begin ph = 2; n = 0; end
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cyc > 0) begin
      chk(line_drv_n === (ph != 2), "R7 drive vs model", line_drv_n, ph != 2);
      chk(brk_busy === (ph == 2), "R7 busy vs model", brk_busy, ph == 2);
      chk(brk_done === m_done, "R7 done vs model", brk_done, m_done);
      if (brk_done === 1'b1) done_seen++;
    end
  end

  task automatic ticks(int cnt, logic lvl);
    for (int i = 0; i < cnt; i++) begin
      line_in = lvl; tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      repeat (TP - 1) @(negedge clk);
    end
  endtask

  task automatic glitchy_low_ticks(int cnt);
    for (int i = 0; i < cnt; i++) begin
      line_in = 1'b0; tick = 1'b1;
      @(negedge clk);
      tick = 1'b0; line_in = 1'b1;
      repeat (TP - 1) @(negedge clk);
    end
    line_in = 1'b0;
  endtask

  task automatic req();
    brk_req = 1'b1; @(negedge clk); brk_req = 1'b0;
  endtask

  task automatic pkt();
    pkt_done = 1'b1; @(negedge clk); pkt_done = 1'b0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R7 watchdog expired act=%0d exp=0", cyc);
    summary();
    $finish;
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    chk(line_drv_n === 1'b1, "R1 reset drive", line_drv_n, 1);
    chk(brk_busy === 1'b0, "R1 reset busy", brk_busy, 0);
    chk(brk_done === 1'b0, "R1 reset done", brk_done, 0);
    rst = 1'b0;
    @(negedge clk);

    // R3 basic break, R7 length
    req();
    ticks(LT, 0); ticks(HT - 1, 1);
    chk(brk_busy === 1'b0, "R3 not before qualification", brk_busy, 0);
    ticks(1, 1);
    chk(line_drv_n === 1'b0, "R3 break starts", line_drv_n, 0);
    d0 = done_seen;
    ticks(BT - 1, 0);
    chk(brk_busy === 1'b1, "R7 still driving", brk_busy, 1);
    ticks(1, 0);
    chk(line_drv_n === 1'b1, "R7 released", line_drv_n, 1);
    chk(done_seen == d0 + 1, "R7 one done pulse", done_seen, d0 + 1);

    // R8 request consumed
    ticks(LT, 0); ticks(HT, 1);
    chk(brk_busy === 1'b0, "R8 no break without new request", brk_busy, 0);

    // R6 late request, saturated count
    req();
    ticks(16, 1);
    chk(brk_busy === 1'b0, "R6 late request ignored", brk_busy, 0);
    // R4 high-only restart after seen high
    ticks(1, 0); ticks(HT, 1);
    chk(brk_busy === 1'b1, "R4 high window restart", brk_busy, 1);
    ticks(BT, 0);

    // R5 low on first high sample
    req();
    ticks(LT, 0); ticks(1, 0); ticks(HT, 1);
    chk(brk_busy === 1'b0, "R5 full restart", brk_busy, 0);
    ticks(LT, 0); ticks(HT, 1);
    chk(brk_busy === 1'b1, "R5 break after new low window", brk_busy, 1);
    ticks(BT, 0);

    // R9 packet restarts detection, ignored in break
    req();
    ticks(LT, 0); ticks(2, 1); pkt(); ticks(2, 1);
    chk(brk_busy === 1'b0, "R9 packet restarts", brk_busy, 0);
    ticks(LT, 0); ticks(HT, 1);
    chk(brk_busy === 1'b1, "R9 break after restart", brk_busy, 1);
    ticks(3, 0); pkt();
    chk(brk_busy === 1'b1, "R9 packet ignored in break", brk_busy, 1);
    ticks(BT - 4, 0);
    chk(brk_busy === 1'b1, "R9 break full length", brk_busy, 1);
    ticks(1, 0);
    chk(brk_busy === 1'b0, "R9 break ends on time", brk_busy, 0);

    // R10 glitches between ticks
    req();
    glitchy_low_ticks(LT); ticks(HT, 1);
    chk(brk_busy === 1'b1, "R10 off-tick glitches ignored", brk_busy, 1);
    ticks(BT, 0);

    // R2 high sample in low window restarts
    req();
    ticks(LT - 1, 0); ticks(1, 1); ticks(LT - 1, 0); ticks(HT, 1);
    chk(brk_busy === 1'b0, "R2 low window restart", brk_busy, 0);
    ticks(LT, 0); ticks(HT, 1);
    chk(brk_busy === 1'b1, "R2 full low window", brk_busy, 1);

    // R1 reset during break
    ticks(2, 0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(line_drv_n === 1'b1, "R1 reset releases line", line_drv_n, 1);
    chk(brk_busy === 1'b0, "R1 reset clears busy", brk_busy, 0);
    rst = 1'b0;
    ticks(LT, 0); ticks(HT, 1);
    chk(brk_busy === 1'b0, "R1 reset drops request", brk_busy, 0);

    summary();
    $finish;
  end

endmodule